// File: doc/BRIEF.md
# Frame-Locked Sync Watchdog

This block follows a field-parity input from an upstream video source and locks to it once per frame. It uses only one edge direction of that input, chosen by a polarity bit. From that edge it runs its own sample and line counters, generates a line sync pulse, and predicts the cycle on which the next frame edge should arrive. When that prediction is missed, a configurable policy decides what the output does next:
- keep running as if the edge had arrived;
- keep sync but blank the picture;
- or go completely dark.

The block restarts cleanly on any later active edge, wherever it lands in the frame.

The parity input can be delayed internally by zero to three clocks. This lets the restart line up with the data phase: with no delay, the clock that registers the edge is the one that loads sample 0, which is the blue-chroma slot of the incoming stream. One select input chooses between the two line standards, 1716 × 525 clocks or 1728 × 625 clocks per frame. Downstream encoder logic uses the counters, the blanking flag and the sync-tip enable.

Top module: `field_lock_watchdog`

## Requirements
- R1: After a synchronous active-low reset, `sample_o` and `line_o` are 0, `black_active_o` is 1, `sync_tip_en_o` is 0 and `hsync_o` sits at its inactive level. The inactive level is low when `hs_pol_i` is 1 and high when it is 0. The block stays in this state until an active field edge arrives.
- R2: Only one edge direction of `field_i` counts: rising when `field_pol_i` is 1, falling when it is 0. An edge in the other direction has no effect on counters or outputs.
- R3: With `dly_i` = 0, the first clock edge on which `field_i` is seen at its new active level loads `sample_o` = 0 and `line_o` = 0. From then on the block produces sync and active video: `black_active_o` = 0 and `sync_tip_en_o` = 1.
- R4: `dly_i` = d (0 to 3) moves the restart d clocks later. With `dly_i` = 2, outputs are unchanged two clocks after the input edge and counters read 0 on the third.
- R5: While running, `sample_o` counts 0 to LEN-1. At each wrap, `line_o` advances and itself wraps after LINES-1. With `std625_i` = 0, LEN and LINES are `LEN_A` and `LINES_A`; with `std625_i` = 1 they are `LEN_B` and `LINES_B`.
- R6: When sync is generated, the line pulse is active for samples 0 to `HS_WIDTH`-1 of each line. It is driven high when `hs_pol_i` = 1 and low when `hs_pol_i` = 0.
- R7: The expected instant is the clock on which the counters sit at the last sample of the last line. An active edge there keeps the frame in step. An active edge at any other position restarts both counters at 0.
- R8: If the expected edge is missing and `free_run_i` = 1, counters, line pulse and sync tips continue and `black_active_o` stays 0. The next active edge, wherever it falls, restarts the counters.
- R9: If the expected edge is missing, `free_run_i` = 0 and `keep_sync_i` = 1, then `black_active_o` = 1 while `sync_tip_en_o` and the line pulse continue.
- R10: If the expected edge is missing and both `free_run_i` and `keep_sync_i` are 0, then `black_active_o` = 1, `sync_tip_en_o` = 0 and `hsync_o` is held inactive.
- R11: An active edge received in any missed-edge state returns the block to locked operation, with `black_active_o` = 0, on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_i | input | 1 | Field-parity input to lock to |
| field_pol_i | input | 1 | 1: rising edge is active, 0: falling edge is active |
| hs_pol_i | input | 1 | 1: line pulse active high, 0: active low |
| free_run_i | input | 1 | Keep running when the expected edge is missing |
| keep_sync_i | input | 1 | Keep sync but blank the picture when not free-running |
| dly_i | input | DLY_W (2) | Internal delay of the field input in clocks |
| std625_i | input | 1 | 0: LEN_A × LINES_A frame, 1: LEN_B × LINES_B frame |
| hsync_o | output | 1 | Derived line sync pulse |
| sample_o | output | SMP_W (11) | Sample position within the line |
| line_o | output | LIN_W (10) | Line position within the frame |
| black_active_o | output | 1 | Active portion of the line is forced black |
| sync_tip_en_o | output | 1 | Analog sync tips are enabled |

## Verification
The bench goes after a few specific corner cases.

- **Edge exactly on the predicted clock.** It places an edge there and another mid-frame. A design that misplaces the expected instant by one clock would fall into a missed-edge state or restart one sample early.
- **The ignored edge direction and the delay taps.** It checks both. A wrong tap shifts every restart, and a design that reacts to both edges restarts twice per field pair.
- **All three missed-edge policies, and the return to lock.** It drives each one and then a recovery edge. A design that swapped the black-with-sync and fully-dark cases would show sync tips or a line pulse where they must be absent.
- **Free-running across a whole frame.** It checks this too: a design that does not carry the counters through, or does not accept a resync edge at an arbitrary position, would leave the counters off by the phase of that edge.

// File: rtl/fls_pkg.sv
// Shared types for the frame-locked sync watchdog.
package fls_pkg;

    // Lock state: idle before first edge, locked, free-running, edge lost.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOCK = 2'd1,
        ST_FREE = 2'd2,
        ST_LOST = 2'd3
    } lock_state_t;

endpackage

// File: rtl/fls_edge_pick.sv
// Delays the field-parity input by 0..(2**DLY_W-1) clocks and flags the
// active edge of the selected tap.
// Assumes field_i is already synchronous to clk.
module fls_edge_pick #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_i,
    input  logic             pol_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             edge_o
);
    localparam int TAPS  = 1 << DLY_W;
    localparam int DEPTH = TAPS - 1;

    logic [DEPTH-1:0] sh_q;
    logic [TAPS-1:0]  taps;
    logic             d_sel;
    logic             prev_q;

    assign taps[0] = field_i;

    // Delay line stages and their taps.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sh_q[0] <= 1'b0;
                    else        sh_q[0] <= field_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sh_q[i] <= 1'b0;
                    else        sh_q[i] <= sh_q[i-1];
                end
            end
            assign taps[i+1] = sh_q[i];
        end
    endgenerate

    assign d_sel = taps[dly_i];

    // Remember the previous value of the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= d_sel;
    end

    // Active edge: the tap moves into the active level chosen by pol_i.
    always_comb begin
        if (pol_i) edge_o = d_sel & ~prev_q;
        else       edge_o = ~d_sel & prev_q;
    end

    // R2: one edge direction only, so two consecutive edge pulses cannot occur.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/fls_frame_timer.sv
// Sample and line counters for one frame.
// Restart loads zero; while run_i is high the counters advance through
// the frame size selected by std_i. frame_end_o marks the last sample of
// the last line, which is the predicted instant of the next frame edge.
// Assumes std_i changes only while the block is not running.
module fls_frame_timer #(
    parameter int LEN_A   = 1716,
    parameter int LINES_A = 525,
    parameter int LEN_B   = 1728,
    parameter int LINES_B = 625,
    parameter int SMP_W   = 11,
    parameter int LIN_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic             std_i,
    output logic [SMP_W-1:0] sample_o,
    output logic [LIN_W-1:0] line_o,
    output logic             frame_end_o
);
    logic [SMP_W-1:0] last_s;
    logic [LIN_W-1:0] last_l;
    logic             line_end;

    // Select the frame size for the active standard.
    always_comb begin
        last_s = std_i ? SMP_W'(LEN_B - 1)   : SMP_W'(LEN_A - 1);
        last_l = std_i ? LIN_W'(LINES_B - 1) : LIN_W'(LINES_A - 1);
    end

    assign line_end    = (sample_o >= last_s);
    assign frame_end_o = run_i && line_end && (line_o >= last_l);

    // Advance or restart the position counters.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            sample_o <= '0;
            line_o   <= '0;
        end else if (run_i) begin
            if (line_end) begin
                sample_o <= '0;
                line_o   <= (line_o >= last_l) ? '0 : line_o + LIN_W'(1);
            end else begin
                sample_o <= sample_o + SMP_W'(1);
            end
        end
    end

    // R3, R7: a restart always yields position zero on the next clock.
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (sample_o == '0) && (line_o == '0));

    // R5: inside a line the sample counter steps by one.
    a_r5_sample_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !line_end) |=> sample_o == $past(sample_o) + SMP_W'(1));

endmodule

// File: rtl/fls_lock_ctrl.sv
// Lock policy state machine.
// Any active edge locks. A missed predicted edge moves to free-running
// or to the lost state, depending on free_run_i.
// Assumes frame_end_i is only high while running.
module fls_lock_ctrl
    import fls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        edge_i,
    input  logic        frame_end_i,
    input  logic        free_run_i,
    output lock_state_t state_o
);
    lock_state_t state_d;

    // Next-state decision for edges and missed edges.
    always_comb begin
        state_d = state_o;
        if (edge_i) begin
            state_d = ST_LOCK;
        end else if (frame_end_i && (state_o == ST_LOCK || state_o == ST_FREE)) begin
            state_d = free_run_i ? ST_FREE : ST_LOST;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_d;
    end

    // R8: a missed edge with free-run enabled keeps running.
    a_r8_free_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOCK && frame_end_i && !edge_i && free_run_i) |=> state_o == ST_FREE);

    // R11: every active edge leads to the locked state.
    a_r11_edge_locks: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> state_o == ST_LOCK);

endmodule

// File: rtl/field_lock_watchdog.sv
// Frame-locked sync watchdog top.
// Locks to one edge direction of a field-parity input, derives a line
// pulse, predicts the next frame edge and applies the missed-edge policy.
// Assumes all inputs are synchronous to clk.
module field_lock_watchdog
    import fls_pkg::*;
#(
    parameter int LEN_A    = 1716,
    parameter int LINES_A  = 525,
    parameter int LEN_B    = 1728,
    parameter int LINES_B  = 625,
    parameter int HS_WIDTH = 128,
    parameter int DLY_W    = 2,
    localparam int MAX_LEN = (LEN_A > LEN_B) ? LEN_A : LEN_B,
    localparam int MAX_LIN = (LINES_A > LINES_B) ? LINES_A : LINES_B,
    localparam int SMP_W   = $clog2(MAX_LEN),
    localparam int LIN_W   = $clog2(MAX_LIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_i,
    input  logic             field_pol_i,
    input  logic             hs_pol_i,
    input  logic             free_run_i,
    input  logic             keep_sync_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             std625_i,
    output logic             hsync_o,
    output logic [SMP_W-1:0] sample_o,
    output logic [LIN_W-1:0] line_o,
    output logic             black_active_o,
    output logic             sync_tip_en_o
);
    logic        edge_w;
    logic        frame_end_w;
    logic        run_w;
    logic        gen_sync;
    logic        hs_act;
    lock_state_t state_w;

    fls_edge_pick #(.DLY_W(DLY_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .field_i(field_i),
        .pol_i  (field_pol_i),
        .dly_i  (dly_i),
        .edge_o (edge_w)
    );

    fls_frame_timer #(
        .LEN_A  (LEN_A),
        .LINES_A(LINES_A),
        .LEN_B  (LEN_B),
        .LINES_B(LINES_B),
        .SMP_W  (SMP_W),
        .LIN_W  (LIN_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (edge_w),
        .run_i      (run_w),
        .std_i      (std625_i),
        .sample_o   (sample_o),
        .line_o     (line_o),
        .frame_end_o(frame_end_w)
    );

    fls_lock_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_w),
        .frame_end_i(frame_end_w),
        .free_run_i (free_run_i),
        .state_o    (state_w)
    );

    assign run_w = (state_w != ST_IDLE);

    // Output policy: sync present unless idle or lost without keep_sync.
    always_comb begin
        gen_sync = (state_w == ST_LOCK) || (state_w == ST_FREE) ||
                   (state_w == ST_LOST && keep_sync_i);
        hs_act         = gen_sync && (sample_o < SMP_W'(HS_WIDTH));
        hsync_o        = hs_pol_i ? hs_act : ~hs_act;
        black_active_o = (state_w == ST_IDLE) || (state_w == ST_LOST);
        sync_tip_en_o  = gen_sync;
    end

    // R10: fully dark when lost without keep_sync.
    a_r10_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_LOST && !keep_sync_i) |-> (!sync_tip_en_o && black_active_o && (hsync_o == !hs_pol_i)));

    // R6: the line pulse never extends past HS_WIDTH samples.
    a_r6_hs_width: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o == hs_pol_i) |-> (sample_o < SMP_W'(HS_WIDTH)));

    // R9: lost with keep_sync gives blanking plus sync tips.
    a_r9_black_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_LOST && keep_sync_i) |-> (black_active_o && sync_tip_en_o));

endmodule

// File: tb/field_lock_watchdog_bench.sv
module field_lock_watchdog_bench;
    localparam int LA = 20, NA = 6, LB = 24, NB = 5, HSW = 4;
    localparam int SW = 5, LW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field = 1'b0, fpol = 1'b1, hpol = 1'b1, frun = 1'b0, ksync = 1'b0, std = 1'b0;
    logic [1:0] dly = 2'd0;
    logic hsync, black, tip;
    logic [SW-1:0] smp;
    logic [LW-1:0] lin;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    // Reference model state.
    logic [2:0] m_hist = '0;
    logic m_prev = 1'b0;
    int m_state = 0, m_s = 0, m_l = 0;

    always #4 clk = ~clk;

    field_lock_watchdog #(
        .LEN_A(LA), .LINES_A(NA), .LEN_B(LB), .LINES_B(NB), .HS_WIDTH(HSW), .DLY_W(2)
    ) u_field_lock_watchdog (
        .clk(clk), .rst_n(rst_n), .field_i(field), .field_pol_i(fpol), .hs_pol_i(hpol),
        .free_run_i(frun), .keep_sync_i(ksync), .dly_i(dly), .std625_i(std),
        .hsync_o(hsync), .sample_o(smp), .line_o(lin),
        .black_active_o(black), .sync_tip_en_o(tip)
    );

    task automatic expect_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model one clock edge from the requirements.
    task automatic model_edge();
        logic dsel, e, fend, run;
        int ln, nl;
        if (!rst_n) begin
            m_hist = '0; m_prev = 1'b0; m_state = 0; m_s = 0; m_l = 0;
            return;
        end
        dsel = (dly == 2'd0) ? field : m_hist[dly - 2'd1];
        e = fpol ? (dsel && !m_prev) : (!dsel && m_prev);
        ln = std ? LB : LA;
        nl = std ? NB : NA;
        run = (m_state != 0);
        fend = run && (m_s == ln - 1) && (m_l == nl - 1);
        if (e) begin
            m_state = 1; m_s = 0; m_l = 0;
        end else begin
            if (run) begin
                if (m_s == ln - 1) begin
                    m_s = 0;
                    m_l = (m_l == nl - 1) ? 0 : m_l + 1;
                end else m_s = m_s + 1;
            end
            if (fend && (m_state == 1 || m_state == 2)) m_state = frun ? 2 : 3;
        end
        m_hist = {m_hist[1:0], field};
        m_prev = dsel;
    endtask

    // Compare all outputs with the model.
    task automatic model_check();
        logic gen, hact;
        string rq;
        gen = (m_state == 1) || (m_state == 2) || (m_state == 3 && ksync);
        hact = gen && (m_s < HSW);
        case (m_state)
            0: rq = "R1";
            1: rq = "R3";
            2: rq = "R8";
            default: rq = ksync ? "R9" : "R10";
        endcase
        expect_val("R5", "sample", int'(smp), m_s);
        expect_val("R5", "line", int'(lin), m_l);
        expect_val("R6", "hsync", int'(hsync), int'(hpol ? hact : !hact));
        expect_val(rq, "black", int'(black), int'(m_state == 0 || m_state == 3));
        expect_val(rq, "tip", int'(tip), int'(gen));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            model_check();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // r1_ reset state
        expect_val("R1", "sample", int'(smp), 0);
        expect_val("R1", "black", int'(black), 1);
        expect_val("R1", "tip", int'(tip), 0);
        expect_val("R1", "hsync", int'(hsync), 0);

        // R2: falling edge active, rising ignored
        fpol = 1'b0; field = 1'b1; step(3);
        expect_val("R2", "black idle", int'(black), 1);
        field = 1'b0; step(1);
        expect_val("R3", "sample", int'(smp), 0);
        expect_val("R3", "black", int'(black), 0);
        expect_val("R3", "tip", int'(tip), 1);
        expect_val("R6", "hsync start", int'(hsync), 1);
        step(5);
        expect_val("R6", "hsync end", int'(hsync), 0);
        field = 1'b1; step(1);
        expect_val("R2", "ignored edge sample", int'(smp), 6);
        step(113);
        expect_val("R7", "last sample", int'(smp), LA - 1);
        expect_val("R7", "last line", int'(lin), NA - 1);
        field = 1'b0; step(1);
        expect_val("R7", "on-time line", int'(lin), 0);
        expect_val("R7", "on-time black", int'(black), 0);
        step(30);
        field = 1'b1; step(1);
        field = 1'b0; step(1);
        expect_val("R7", "resync sample", int'(smp), 0);
        expect_val("R7", "resync line", int'(lin), 0);

        // R8 free run
        frun = 1'b1; step(120);
        expect_val("R8", "free black", int'(black), 0);
        expect_val("R8", "free tip", int'(tip), 1);
        step(40);
        field = 1'b1; step(1);
        field = 1'b0; step(1);
        expect_val("R8", "resync sample", int'(smp), 0);
        expect_val("R8", "resync line", int'(lin), 0);

        // R9 black with sync
        frun = 1'b0; ksync = 1'b1; step(120);
        expect_val("R9", "black", int'(black), 1);
        expect_val("R9", "tip", int'(tip), 1);
        expect_val("R9", "hsync", int'(hsync), 1);

        // R10 full dark
        ksync = 1'b0; step(20);
        expect_val("R10", "sample", int'(smp), 0);
        expect_val("R10", "hsync", int'(hsync), 0);
        expect_val("R10", "tip", int'(tip), 0);

        // R11 recover
        field = 1'b1; step(1);
        field = 1'b0; step(1);
        expect_val("R11", "black", int'(black), 0);
        expect_val("R11", "tip", int'(tip), 1);
        hpol = 1'b0; step(1);
        expect_val("R6", "low-active hsync", int'(hsync), 0);

        // R4 delay and R5 second standard
        hpol = 1'b1; fpol = 1'b1; dly = 2'd2; std = 1'b1;
        do_reset();
        field = 1'b1; step(2);
        expect_val("R4", "still idle", int'(black), 1);
        step(1);
        expect_val("R4", "delayed start", int'(smp), 0);
        expect_val("R4", "delayed black", int'(black), 0);
        step(LB);
        expect_val("R5", "line wrap sample", int'(smp), 0);
        expect_val("R5", "line wrap line", int'(lin), 1);
        step(LB * (NB - 1));
        expect_val("R5", "frame wrap line", int'(lin), 0);
        expect_val("R10", "lost black", int'(black), 1);

        // Random segments checked against the model.
        for (int seg = 0; seg < 40; seg++) begin
            if (($urandom % 4) == 0) begin
                std = 1'($urandom);
                do_reset();
            end
            fpol = 1'($urandom); hpol = 1'($urandom);
            frun = 1'($urandom); ksync = 1'($urandom);
            dly = 2'($urandom);
            for (int c = 0; c < 400; c++) begin
                if (($urandom % 60) == 0) field = ~field;
                step(1);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule